// File: doc/BRIEF.md
# Multidrop Nine-Bit Serial Channel

This block pairs an asynchronous serial transmitter with a receiver for use on a shared line, where one master addresses several peripheral stations. In multidrop framing every character carries a ninth bit after its eight data bits. A one in that bit marks the byte as a station address and a zero marks it as payload. Software on the master selects the bit through a flag in the mode register before each byte. A typical sequence is: flag set, address byte, flag cleared, data bytes, flag set again for the next address.

Software writes bytes through a parallel port guarded by a transmit-ready flag. Received bytes are read from a small FIFO. Each entry returns the byte together with the ninth bit that arrived with it, so a peripheral can tell addresses from payload without extra decoding. Bit timing comes from an external enable pulse at sixteen times the bit rate. Any other value of the format field gives a plain frame without the ninth bit.

Top module: `md9_serial_chan`

## Requirements
- R1: `txd` idles high. A frame is one low start bit, then eight data bits with the LSB first, then (in multidrop format only) the ninth bit, then one high stop bit. Each bit lasts 16 `tick16` pulses.
- R2: Format field value 2'b11 selects multidrop framing (11 bits per frame). Every other value selects plain framing (10 bits, with the stop bit straight after data bit 7). The transmitter samples the format when a byte is accepted. The receiver samples it when a start bit is detected.
- R3: A write on `tx_we` is accepted only while `tx_rdy` is high. `tx_rdy` reads low on the cycle after an accepted write. A write while `tx_rdy` is low is ignored and never reaches the line.
- R4: The transmitted ninth bit equals `cfg_addr` as it stood on the cycle the byte was accepted. Changing `cfg_addr` afterwards does not alter that character.
- R5: The holding register can take a new byte while an earlier frame is still shifting out. Accepted bytes leave the line in write order.
- R6: Each received character returns its byte on `rx_data` and its ninth bit on `rx_flag` (1 = address, 0 = data). In plain format `rx_flag` reads 0.
- R7: A low level on `rxd` that is no longer low at the middle of the start bit (8 ticks after detection) is treated as noise, and no character results.
- R8: A character whose stop bit is sampled low is discarded. The receiver then waits for the line to return high before it looks for the next start bit.
- R9: Received characters queue in a FIFO of RX_DEPTH (default 4) entries. `rx_rdy` is high while the FIFO is not empty, and `rx_data`/`rx_flag` show the oldest entry. A pulse on `rx_re` removes it. Characters that arrive while the FIFO is full are dropped. `rx_re` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x bit rate |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_fmt | input | 2 | Format field; 2'b11 = multidrop |
| cfg_addr | input | 1 | Ninth-bit value for following transmit writes |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_data | input | DATA_W | Byte to transmit |
| tx_rdy | output | 1 | Transmit holding register empty |
| rx_re | input | 1 | Pop the oldest received character |
| rx_data | output | DATA_W | Oldest received byte |
| rx_flag | output | 1 | Ninth bit of the oldest received character |
| rx_rdy | output | 1 | At least one unread character |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
An accepted write drops `tx_rdy` on the next clock edge, so the bench samples it at the falling edge that follows. When the transmitter is idle, the start bit reaches `txd` one edge after acceptance. The bench's line decoder detects the start bit on a falling edge, then samples 8 cycles later and every 16 cycles after that (with `tick16` held high), which lands each sample in the middle of its bit. The receiver adds two synchroniser stages and pushes a character at the middle of the stop bit. Receive checks therefore poll `rx_rdy` over a bounded window before comparing `rx_data` and `rx_flag`, and the "ignored" and "dropped" cases are settled only after a wait longer than a whole frame.

// File: rtl/md9_pkg.sv
package md9_pkg;
  localparam logic [1:0] FMT_MULTIDROP = 2'b11;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;
endpackage

// File: rtl/md9_tx.sv
module md9_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_flag,
  input  logic              md,
  output logic              rdy,
  output logic              busy,
  output logic              txd
);
  localparam int FRW  = DATA_W + 3;
  localparam int CNTW = $clog2(FRW + 1);
  localparam int SUBW = $clog2(OSR);

  logic              hold_full_q, hold_full_d;
  logic [DATA_W-1:0] hold_data_q, hold_data_d;
  logic              hold_flag_q, hold_flag_d;
  logic              hold_md_q, hold_md_d;
  logic              busy_q, busy_d;
  logic [FRW-1:0]    frame_q, frame_d;
  logic [CNTW-1:0]   nbits_q, nbits_d;
  logic [CNTW-1:0]   bit_q, bit_d;
  logic [SUBW-1:0]   sub_q, sub_d;
  logic              txd_q, txd_d;

  always_comb begin
    hold_full_d = hold_full_q;
    hold_data_d = hold_data_q;
    hold_flag_d = hold_flag_q;
    hold_md_d   = hold_md_q;
    busy_d      = busy_q;
    frame_d     = frame_q;
    nbits_d     = nbits_q;
    bit_d       = bit_q;
    sub_d       = sub_q;
    txd_d       = txd_q;
    if (wr_en && !hold_full_q) begin
      hold_full_d = 1'b1;
      hold_data_d = wr_data;
      hold_flag_d = wr_flag;
      hold_md_d   = md;
    end
    if (!busy_q && hold_full_q) begin
      hold_full_d = 1'b0;
      busy_d      = 1'b1;
      frame_d     = hold_md_q ? {1'b1, hold_flag_q, hold_data_q, 1'b0}
                              : {1'b1, 1'b1, hold_data_q, 1'b0};
      nbits_d     = hold_md_q ? CNTW'(FRW) : CNTW'(FRW - 1);
      bit_d       = '0;
      sub_d       = '0;
      txd_d       = 1'b0;
    end else if (busy_q && tick) begin
      if (sub_q == SUBW'(OSR - 1)) begin
        sub_d = '0;
        if (bit_q == nbits_q - 1'b1) begin
          busy_d = 1'b0;
          txd_d  = 1'b1;
        end else begin
          bit_d   = bit_q + 1'b1;
          frame_d = frame_q >> 1;
          txd_d   = frame_q[1];
        end
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      hold_data_q <= '0;
      hold_flag_q <= 1'b0;
      hold_md_q   <= 1'b0;
      busy_q      <= 1'b0;
      frame_q     <= '1;
      nbits_q     <= '0;
      bit_q       <= '0;
      sub_q       <= '0;
      txd_q       <= 1'b1;
    end else begin
      hold_full_q <= hold_full_d;
      hold_data_q <= hold_data_d;
      hold_flag_q <= hold_flag_d;
      hold_md_q   <= hold_md_d;
      busy_q      <= busy_d;
      frame_q     <= frame_d;
      nbits_q     <= nbits_d;
      bit_q       <= bit_d;
      sub_q       <= sub_d;
      txd_q       <= txd_d;
    end
  end

  assign rdy  = !hold_full_q;
  assign busy = busy_q;
  assign txd  = txd_q;
endmodule

// File: rtl/md9_rx.sv
module md9_rx
  import md9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              md,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              push_flag,
  output logic              md_active
);
  localparam int SUBW = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int BITW = $clog2(DATA_W);

  logic              s1_q, s2_q;
  rx_state_e         st_q, st_d;
  logic [SUBW-1:0]   sub_q, sub_d;
  logic [BITW-1:0]   bit_q, bit_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              flag_q, flag_d;
  logic              md_q, md_d;
  logic              push_d;
  logic              at_bit_end;

  assign at_bit_end = tick && (sub_q == SUBW'(OSR - 1));

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    bit_d  = bit_q;
    shf_d  = shf_q;
    flag_d = flag_q;
    md_d   = md_q;
    push_d = 1'b0;
    if (tick && st_q != RX_IDLE && st_q != RX_WAIT_HIGH) begin
      sub_d = at_bit_end ? '0 : sub_q + 1'b1;
    end
    unique case (st_q)
      RX_IDLE: begin
        if (!s2_q) begin
          st_d  = RX_START;
          sub_d = '0;
          md_d  = md;
        end
      end
      RX_START: begin
        if (tick && sub_q == SUBW'(HALF - 1)) begin
          sub_d = '0;
          bit_d = '0;
          st_d  = s2_q ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (at_bit_end) begin
          shf_d = {s2_q, shf_q[DATA_W-1:1]};
          if (bit_q == BITW'(DATA_W - 1)) begin
            flag_d = 1'b0;
            st_d   = md_q ? RX_NINTH : RX_STOP;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      RX_NINTH: begin
        if (at_bit_end) begin
          flag_d = s2_q;
          st_d   = RX_STOP;
        end
      end
      RX_STOP: begin
        if (at_bit_end) begin
          push_d = s2_q;
          st_d   = s2_q ? RX_IDLE : RX_WAIT_HIGH;
        end
      end
      RX_WAIT_HIGH: begin
        if (s2_q) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      st_q   <= RX_IDLE;
      sub_q  <= '0;
      bit_q  <= '0;
      shf_q  <= '0;
      flag_q <= 1'b0;
      md_q   <= 1'b0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      st_q   <= st_d;
      sub_q  <= sub_d;
      bit_q  <= bit_d;
      shf_q  <= shf_d;
      flag_q <= flag_d;
      md_q   <= md_d;
    end
  end

  assign push      = push_d;
  assign push_data = shf_q;
  assign push_flag = flag_q;
  assign md_active = md_q;
endmodule

// File: rtl/md9_fifo.sv
module md9_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       pop,
  output logic [WIDTH-1:0]           rdata,
  output logic                       not_empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    wr_d  = do_push ? bump(wr_q) : wr_q;
    rd_d  = do_pop ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= wdata;
  end

  assign rdata     = mem_q[rd_q];
  assign not_empty = (cnt_q != '0);
  assign count     = cnt_q;
endmodule

// File: rtl/md9_serial_chan.sv
module md9_serial_chan
  import md9_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OSR      = 16,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_addr,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_rdy,
  input  logic              rx_re,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_flag,
  output logic              rx_rdy,
  input  logic              rxd,
  output logic              txd
);
  localparam int CW = $clog2(RX_DEPTH + 1);

  logic [1:0]        fmt_q, fmt_d;
  logic              addr_q, addr_d;
  logic              md_sel;
  logic              tx_busy;
  logic              rx_push;
  logic [DATA_W-1:0] rx_push_data;
  logic              rx_push_flag;
  logic              rx_md;
  logic [DATA_W:0]   rx_head;
  logic [CW-1:0]     rx_count;

  always_comb begin
    fmt_d  = fmt_q;
    addr_d = addr_q;
    if (cfg_we) begin
      fmt_d  = cfg_fmt;
      addr_d = cfg_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= 2'b00;
      addr_q <= 1'b0;
    end else begin
      fmt_q  <= fmt_d;
      addr_q <= addr_d;
    end
  end

  assign md_sel = (fmt_q == FMT_MULTIDROP);

  md9_tx #(.DATA_W(DATA_W), .OSR(OSR)) tx_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .wr_en   (tx_we),
    .wr_data (tx_data),
    .wr_flag (addr_q),
    .md      (md_sel),
    .rdy     (tx_rdy),
    .busy    (tx_busy),
    .txd     (txd)
  );

  md9_rx #(.DATA_W(DATA_W), .OSR(OSR)) rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .rxd       (rxd),
    .md        (md_sel),
    .push      (rx_push),
    .push_data (rx_push_data),
    .push_flag (rx_push_flag),
    .md_active (rx_md)
  );

  md9_fifo #(.WIDTH(DATA_W + 1), .DEPTH(RX_DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .wdata     ({rx_push_flag, rx_push_data}),
    .pop       (rx_re),
    .rdata     (rx_head),
    .not_empty (rx_rdy),
    .count     (rx_count)
  );

  assign rx_data = rx_head[DATA_W-1:0];
  assign rx_flag = rx_head[DATA_W];
endmodule

// File: rtl/md9_chk.sv
module md9_chk #(
  parameter int DATA_W   = 8,
  parameter int RX_DEPTH = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tx_we,
  input logic                          tx_rdy,
  input logic                          txd,
  input logic                          tx_busy,
  input logic                          rx_re,
  input logic                          rx_rdy,
  input logic [DATA_W-1:0]             rx_data,
  input logic                          rx_flag,
  input logic [$clog2(RX_DEPTH+1)-1:0] rx_count,
  input logic                          rx_push,
  input logic                          rx_push_flag,
  input logic                          rx_md
);
  // R1: line high whenever no frame is in flight
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R1: a frame begins with a low start bit
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  // R3: an accepted write occupies the holding register
  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_we && tx_rdy) |=> !tx_rdy);

  // R6: plain frames never carry an address mark
  p_plain_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_md) |-> !rx_push_flag);

  // R9: head entry holds until popped
  p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rdy && !rx_re) |=> (rx_rdy && $stable(rx_data) && $stable(rx_flag)));

  // R9: occupancy never exceeds the FIFO depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_count) <= RX_DEPTH);
endmodule

bind md9_serial_chan md9_chk #(.DATA_W(DATA_W), .RX_DEPTH(RX_DEPTH)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_we        (tx_we),
  .tx_rdy       (tx_rdy),
  .txd          (txd),
  .tx_busy      (tx_busy),
  .rx_re        (rx_re),
  .rx_rdy       (rx_rdy),
  .rx_data      (rx_data),
  .rx_flag      (rx_flag),
  .rx_count     (rx_count),
  .rx_push      (rx_push),
  .rx_push_flag (rx_push_flag),
  .rx_md        (rx_md)
);

// File: tb/md9_serial_chan_tb.sv
`timescale 1ns/1ps
module md9_serial_chan_tb_top;
  logic       clk;
  logic       rst_n;
  logic       tick16;
  logic       cfg_we;
  logic [1:0] cfg_fmt;
  logic       cfg_addr;
  logic       tx_we;
  logic [7:0] tx_data;
  logic       tx_rdy;
  logic       rx_re;
  logic [7:0] rx_data;
  logic       rx_flag;
  logic       rx_rdy;
  logic       rxd;
  logic       txd;
  logic       loop;
  logic       rxd_b;

  int n_chk;
  int n_bad;
  bit finished;

  assign rxd = loop ? txd : rxd_b;

  md9_serial_chan dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16),
    .cfg_we(cfg_we), .cfg_fmt(cfg_fmt), .cfg_addr(cfg_addr),
    .tx_we(tx_we), .tx_data(tx_data), .tx_rdy(tx_rdy),
    .rx_re(rx_re), .rx_data(rx_data), .rx_flag(rx_flag), .rx_rdy(rx_rdy),
    .rxd(rxd), .txd(txd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] fmt, input logic addr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fmt = fmt; cfg_addr = addr;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_tx(input logic [7:0] d);
    @(negedge clk);
    while (!tx_rdy) @(negedge clk);
    tx_we = 1'b1; tx_data = d;
    @(negedge clk);
    tx_we = 1'b0;
  endtask

  // samples the middle of each bit of the next frame on txd
  task automatic capture(output logic [10:0] bits);
    bits = '1;
    while (txd !== 1'b0) @(negedge clk);
    repeat (8) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < 11; i++) begin
      repeat (16) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  function automatic logic [10:0] md_frame(input logic [7:0] d, input logic f);
    return {1'b1, f, d, 1'b0};
  endfunction

  task automatic drive_frame(input logic [7:0] d, input logic f, input bit md, input logic stopv);
    @(negedge clk);
    rxd_b = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_b = d[i];
      repeat (16) @(negedge clk);
    end
    if (md) begin
      rxd_b = f;
      repeat (16) @(negedge clk);
    end
    rxd_b = stopv;
    repeat (16) @(negedge clk);
    rxd_b = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_rx(input logic [7:0] ed, input logic ef, input string req);
    int w;
    w = 0;
    @(negedge clk);
    while (!rx_rdy && w < 64) begin
      @(negedge clk);
      w++;
    end
    check({req, " rx_rdy"}, 32'(rx_rdy), 32'd1);
    check({req, " rx_data"}, 32'(rx_data), 32'(ed));
    check({req, " rx_flag"}, 32'(rx_flag), 32'(ef));
    rx_re = 1'b1;
    @(negedge clk);
    rx_re = 1'b0;
  endtask

  task automatic send_and_check(input logic [7:0] d, input logic f, input string req);
    logic [10:0] bits;
    fork
      capture(bits);
      write_tx(d);
    join
    check({req, " frame"}, 32'(bits), 32'(md_frame(d, f)));
    read_rx(d, f, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset txd", 32'(txd), 32'd1);
    check("R3 reset tx_rdy", 32'(tx_rdy), 32'd1);
    check("R9 reset rx_rdy", 32'(rx_rdy), 32'd0);
  endtask

  // master sequence: address, data, address
  task automatic t_master_seq();
    loop = 1'b1;
    set_cfg(2'b11, 1'b1);
    send_and_check(8'h5A, 1'b1, "R1 R6 addr");
    set_cfg(2'b11, 1'b0);
    send_and_check(8'h3C, 1'b0, "R4 R6 data");
    set_cfg(2'b11, 1'b1);
    send_and_check(8'hA5, 1'b1, "R4 R6 addr2");
  endtask

  task automatic t_flag_late();
    logic [10:0] bits;
    loop = 1'b1;
    set_cfg(2'b11, 1'b1);
    fork
      capture(bits);
      begin
        @(negedge clk);
        tx_we = 1'b1; tx_data = 8'hC3;
        @(negedge clk);
        tx_we = 1'b0;
        cfg_we = 1'b1; cfg_fmt = 2'b11; cfg_addr = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    check("R4 late flag change frame", 32'(bits), 32'(md_frame(8'hC3, 1'b1)));
    read_rx(8'hC3, 1'b1, "R4 late flag rx");
  endtask

  task automatic t_plain();
    logic [10:0] bits;
    loop = 1'b1;
    set_cfg(2'b01, 1'b0);
    fork
      capture(bits);
      write_tx(8'h81);
    join
    check("R2 plain frame", 32'(bits), 32'({2'b11, 8'h81, 1'b0}));
    read_rx(8'h81, 1'b0, "R2 R6 plain rx");
  endtask

  task automatic t_back_to_back();
    logic [10:0] b1, b2;
    bit extra;
    loop = 1'b1;
    set_cfg(2'b11, 1'b0);
    fork
      begin
        capture(b1);
        capture(b2);
      end
      begin
        @(negedge clk);
        tx_we = 1'b1; tx_data = 8'h11;
        @(negedge clk);
        check("R3 rdy low after write", 32'(tx_rdy), 32'd0);
        tx_data = 8'h22;
        @(negedge clk);
        tx_we = 1'b0;
        repeat (5) @(negedge clk);
        check("R5 rdy high while shifting", 32'(tx_rdy), 32'd1);
        tx_we = 1'b1; tx_data = 8'h33;
        @(negedge clk);
        check("R3 rdy low second write", 32'(tx_rdy), 32'd0);
        tx_data = 8'h44;
        @(negedge clk);
        tx_we = 1'b0;
      end
    join
    check("R5 first frame", 32'(b1), 32'(md_frame(8'h11, 1'b0)));
    check("R5 second frame", 32'(b2), 32'(md_frame(8'h33, 1'b0)));
    extra = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (txd === 1'b0) extra = 1'b1;
    end
    check("R3 ignored writes not sent", 32'(extra), 32'd0);
    read_rx(8'h11, 1'b0, "R5 rx first");
    read_rx(8'h33, 1'b0, "R5 rx second");
    check("R3 no third character", 32'(rx_rdy), 32'd0);
  endtask

  task automatic t_false_start();
    loop = 1'b0;
    rxd_b = 1'b1;
    set_cfg(2'b11, 1'b0);
    @(negedge clk);
    rxd_b = 1'b0;
    repeat (4) @(negedge clk);
    rxd_b = 1'b1;
    repeat (300) @(negedge clk);
    check("R7 glitch ignored", 32'(rx_rdy), 32'd0);
  endtask

  task automatic t_bad_stop();
    loop = 1'b0;
    set_cfg(2'b11, 1'b0);
    drive_frame(8'h55, 1'b1, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    check("R8 bad stop discarded", 32'(rx_rdy), 32'd0);
    drive_frame(8'h66, 1'b0, 1'b1, 1'b1);
    read_rx(8'h66, 1'b0, "R8 recovery");
  endtask

  task automatic t_fifo_full();
    loop = 1'b0;
    set_cfg(2'b11, 1'b0);
    for (int i = 0; i < 5; i++) drive_frame(8'(8'h10 + i), i[0], 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) read_rx(8'(8'h10 + i), i[0], "R9 fifo order");
    @(negedge clk);
    check("R9 fifth dropped", 32'(rx_rdy), 32'd0);
    rx_re = 1'b1;
    @(negedge clk);
    rx_re = 1'b0;
    @(negedge clk);
    check("R9 pop on empty ignored", 32'(rx_rdy), 32'd0);
    drive_frame(8'h77, 1'b1, 1'b1, 1'b1);
    read_rx(8'h77, 1'b1, "R9 after empty pop");
    check("R9 empty again", 32'(rx_rdy), 32'd0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    tick16 = 1'b1;
    cfg_we = 1'b0; cfg_fmt = 2'b00; cfg_addr = 1'b0;
    tx_we = 1'b0; tx_data = '0; rx_re = 1'b0;
    loop = 1'b1; rxd_b = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_master_seq();
    t_flag_late();
    t_plain();
    t_back_to_back();
    t_false_start();
    t_bad_stop();
    t_fifo_full();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL all watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule